// File: doc/BRIEF.md
# Filter Trim Calibration Sequencer

This block runs on the host side of an ultrasonic receiver front end. It tunes the 7-bit center-frequency trim of the receiver's band-pass filter. The receiver answers every configuration read with a calibration pulse on its shared data line, and the width of that pulse tracks the filter's center frequency. A `start` pulse launches the sequence. The sequencer first reads the configuration register to capture the fields it must leave alone. It then runs a most-significant-bit-first binary search over the trim code, with one write and one read-plus-measure per probe. Each pulse is timed from its rising edge to its falling edge in system-clock cycles.

The sequencer remembers the trim whose pulse came closest to the target width. That trim may not be the last one probed. The sequencer writes it back and leaves configuration mode. It then disregards the data line for a settle interval while the filter output chatters, and only after that does it raise `done`. If a pulse never appears, or stays high far too long, the sequencer flags an error and writes a safe default trim instead. Bit-level signalling on the two-wire bus belongs to a separate master, which the sequencer drives through a valid/ack request port.

Top module: `trim_cal_ctrl`

## Requirements
- R1: Every write request carries, in bits [15:7] of `req_wdata`, the bits [15:7] last returned by a read. The trim sits in bits [6:0].
- R2: `req_op` encodes read=1, write=2, exit=3. A successful run issues exactly 8 reads, 8 writes and 1 exit. It begins with a read, then alternates write and read, and ends with the final write and then the exit.
- R3: The first probe written is 64 (only trim bit 6 set). Each later probe sets the next lower bit.
- R4: With the default polarity, a measured width greater than the target keeps the bit under test at 1. A width equal to or below the target clears it.
- R5: The final write carries the probed or initially read trim with the smallest absolute width error, even when that trim is not the last probe.
- R6: The pulse width is the number of clock cycles `data_in` is high, from its rise to its fall. On success `cal_err` is 0 and `cal_trim` equals the final written trim.
- R7: If no rising edge is seen within TIMEOUT_CYC cycles of a read, `cal_err` becomes 1. The sequencer writes DEFAULT_TRIM (44) with the preserved fields, then exits.
- R8: If a pulse stays high for 4 x the target width, `cal_err` becomes 1 and the sequencer recovers as in R7.
- R9: `done` is high for one cycle, exactly SETTLE_CYC cycles after the cycle in which the exit is acknowledged. `data_in` activity during that interval changes neither the timing nor the requests.
- R10: After reset `busy`, `done` and `req_valid` are 0.
- R11: While `req_valid` is high and not yet acknowledged, `req_valid`, `req_op` and `req_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a calibration run when idle |
| busy | output | 1 | High from start until done |
| done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Last run aborted on a missing or stuck pulse |
| cal_trim | output | TRIM_W | Trim written by the last run |
| req_valid | output | 1 | Bus request pending |
| req_op | output | 2 | Request kind: 1 read, 2 write, 3 exit |
| req_wdata | output | REG_W | Register value for a write |
| req_ack | input | 1 | Master finished the request (one cycle) |
| req_rdata | input | REG_W | Register value returned with a read ack |
| data_in | input | 1 | Sensed level of the shared data line |

## Verification
A corrupted probe register or a wrong bit index shows on `req_wdata` at the very next write, one bus transaction after the measurement that caused it. A stale best-match register shows only on the final write and on `cal_trim`, so the bench includes a case where the closest trim is not the last probe. A miscounted settle timer or a meter that reacts to `data_in` after exit moves `done` off its exact cycle, and the bench compares that cycle against the exit acknowledge.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_EXIT  = 2'd3
   } bus_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_MEAS,
      ST_EVAL,
      ST_WRITE,
      ST_EXIT,
      ST_SETTLE
   } seq_state_e;

endpackage

// File: rtl/trim_pulse_meter.sv
module trim_pulse_meter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT_CYC = 50000,
   parameter int unsigned LIMIT_CYC   = 37500,
   localparam int unsigned CW = $clog2(LIMIT_CYC + 1),
   localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          din,
   output logic          meas_done,
   output logic          meas_fail,
   output logic [CW-1:0] meas_width
);

   logic lvl;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign lvl = din;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], din};
      end
      assign lvl = sh[SYNC_STAGES-1];
   end

   typedef enum logic [1:0] {M_IDLE, M_WAIT, M_HIGH} meter_e;
   meter_e        mst;
   logic [TW-1:0] tcnt;
   logic [CW-1:0] hcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mst        <= M_IDLE;
         tcnt       <= '0;
         hcnt       <= '0;
         meas_done  <= 1'b0;
         meas_fail  <= 1'b0;
         meas_width <= '0;
      end else begin
         meas_done <= 1'b0;
         meas_fail <= 1'b0;
         case (mst)
            M_IDLE: if (arm) begin
               mst  <= M_WAIT;
               tcnt <= '0;
            end
            M_WAIT: begin
               if (lvl) begin
                  mst  <= M_HIGH;
                  hcnt <= CW'(1);
               end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
                  mst       <= M_IDLE;
                  meas_fail <= 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            M_HIGH: begin
               if (!lvl) begin
                  mst        <= M_IDLE;
                  meas_done  <= 1'b1;
                  meas_width <= hcnt;
               end else if (hcnt == CW'(LIMIT_CYC)) begin
                  mst       <= M_IDLE;
                  meas_fail <= 1'b1;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            default: mst <= M_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trim_search.sv
module trim_search #(
   parameter int unsigned TRIM_W      = 7,
   parameter int unsigned EW          = 16,
   parameter bit          INC_ON_WIDE = 1'b1,
   localparam int unsigned IW = (TRIM_W > 1) ? $clog2(TRIM_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic              step,
   input  logic [TRIM_W-1:0] meas_trim,
   input  logic [EW-1:0]     meas_err,
   input  logic              wide,
   output logic [TRIM_W-1:0] probe,
   output logic [TRIM_W-1:0] best_trim,
   output logic              last
);

   logic [IW-1:0] idx;
   logic [EW-1:0] best_err;
   logic          keep;

   if (INC_ON_WIDE) begin : g_pol_inc
      assign keep = wide;
   end else begin : g_pol_dec
      assign keep = ~wide;
   end

   assign last = (idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         probe     <= '0;
         idx       <= '0;
         best_trim <= '0;
         best_err  <= '1;
      end else if (clr) begin
         probe           <= '0;
         probe[TRIM_W-1] <= 1'b1;
         idx             <= IW'(TRIM_W - 1);
         best_err        <= '1;
      end else begin
         if (upd && (meas_err < best_err)) begin
            best_err  <= meas_err;
            best_trim <= meas_trim;
         end
         if (step) begin
            probe[idx] <= keep;
            if (idx != '0) begin
               probe[idx - 1'b1] <= 1'b1;
               idx               <= idx - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
   import trim_cal_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 125_000_000,
   parameter int unsigned TARGET_NS    = 75_000,
   parameter int unsigned TIMEOUT_CYC  = 50_000,
   parameter int unsigned SETTLE_CYC   = 62_500,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned REG_W        = 16,
   parameter int unsigned TRIM_W       = 7,
   parameter int unsigned DEFAULT_TRIM = 44,
   parameter bit          INC_ON_WIDE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              cal_err,
   output logic [TRIM_W-1:0] cal_trim,
   output logic              req_valid,
   output logic [1:0]        req_op,
   output logic [REG_W-1:0]  req_wdata,
   input  logic              req_ack,
   input  logic [REG_W-1:0]  req_rdata,
   input  logic              data_in
);

   localparam longint unsigned TARGET_L =
      (longint'(CLK_HZ) * longint'(TARGET_NS)) / 64'd1_000_000_000;
   localparam int unsigned TARGET_CYC = int'(TARGET_L);
   localparam int unsigned LIMIT_CYC  = 4 * TARGET_CYC;
   localparam int unsigned CW         = $clog2(LIMIT_CYC + 1);
   localparam int unsigned SW         = $clog2(SETTLE_CYC + 2);
   localparam int unsigned UW         = REG_W - TRIM_W;

   if (TRIM_W < 2 || TRIM_W >= REG_W) begin : g_bad_trim_w
      $error("trim field width must be at least 2 and below the register width");
   end
   if (DEFAULT_TRIM >= (1 << TRIM_W)) begin : g_bad_default
      $error("default trim does not fit the trim field");
   end
   if (TARGET_CYC < 2) begin : g_bad_target
      $error("target pulse width is under two clock cycles");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("rise timeout too short");
   end

   seq_state_e        st;
   logic              first;
   logic              final_w;
   logic              abort;
   logic [UW-1:0]     upper;
   logic [TRIM_W-1:0] cur;
   logic [SW-1:0]     scnt;
   logic [TRIM_W-1:0] res_trim;

   logic              m_done, m_fail;
   logic [CW-1:0]     m_width;
   logic              wide;
   logic [CW-1:0]     abs_err;
   logic [TRIM_W-1:0] probe, best_trim, wr_trim;
   logic              last;
   logic              s_clr, s_upd, s_step, m_arm;

   assign wide    = (m_width > CW'(TARGET_CYC));
   assign abs_err = wide ? (m_width - CW'(TARGET_CYC)) : (CW'(TARGET_CYC) - m_width);

   assign s_clr  = (st == ST_IDLE) && start;
   assign s_upd  = (st == ST_EVAL);
   assign s_step = (st == ST_EVAL) && !first;
   assign m_arm  = (st == ST_READ) && req_ack;

   trim_pulse_meter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TIMEOUT_CYC(TIMEOUT_CYC),
      .LIMIT_CYC  (LIMIT_CYC)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (m_arm),
      .din       (data_in),
      .meas_done (m_done),
      .meas_fail (m_fail),
      .meas_width(m_width)
   );

   trim_search #(
      .TRIM_W     (TRIM_W),
      .EW         (CW),
      .INC_ON_WIDE(INC_ON_WIDE)
   ) u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (s_clr),
      .upd      (s_upd),
      .step     (s_step),
      .meas_trim(cur),
      .meas_err (abs_err),
      .wide     (wide),
      .probe    (probe),
      .best_trim(best_trim),
      .last     (last)
   );

   always_comb begin
      if (abort)        wr_trim = TRIM_W'(DEFAULT_TRIM);
      else if (final_w) wr_trim = best_trim;
      else              wr_trim = probe;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         first    <= 1'b0;
         final_w  <= 1'b0;
         abort    <= 1'b0;
         upper    <= '0;
         cur      <= '0;
         scnt     <= '0;
         res_trim <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               first   <= 1'b1;
               final_w <= 1'b0;
               abort   <= 1'b0;
               st      <= ST_READ;
            end
            ST_READ: if (req_ack) begin
               upper <= req_rdata[REG_W-1:TRIM_W];
               if (first) cur <= req_rdata[TRIM_W-1:0];
               st <= ST_MEAS;
            end
            ST_MEAS: begin
               if (m_fail) begin
                  abort   <= 1'b1;
                  final_w <= 1'b1;
                  st      <= ST_WRITE;
               end else if (m_done) begin
                  st <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               first   <= 1'b0;
               final_w <= !first && last;
               st      <= ST_WRITE;
            end
            ST_WRITE: if (req_ack) begin
               if (final_w) begin
                  res_trim <= wr_trim;
                  st       <= ST_EXIT;
               end else begin
                  cur <= probe;
                  st  <= ST_READ;
               end
            end
            ST_EXIT: if (req_ack) begin
               scnt <= SW'(SETTLE_CYC);
               st   <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (scnt == '0) st <= ST_IDLE;
               else            scnt <= scnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_valid = 1'b0;
      req_op    = OP_NONE;
      req_wdata = '0;
      case (st)
         ST_READ:  begin req_valid = 1'b1; req_op = OP_READ; end
         ST_WRITE: begin req_valid = 1'b1; req_op = OP_WRITE; req_wdata = {upper, wr_trim}; end
         ST_EXIT:  begin req_valid = 1'b1; req_op = OP_EXIT; end
         default:  ;
      endcase
   end

   assign busy     = (st != ST_IDLE);
   assign done     = (st == ST_SETTLE) && (scnt == '0);
   assign cal_err  = abort;
   assign cal_trim = res_trim;

endmodule

// File: rtl/trim_cal_chk.sv
module trim_cal_chk #(
   parameter int unsigned REG_W        = 16,
   parameter int unsigned TRIM_W       = 7,
   parameter int unsigned DEFAULT_TRIM = 44
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              cal_err,
   input logic [TRIM_W-1:0] cal_trim,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [REG_W-1:0]  req_wdata,
   input logic              req_ack,
   input logic [REG_W-1:0]  req_rdata
);

   logic [REG_W-TRIM_W-1:0] seen_up;
   logic                    seen_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_up  <= '0;
         seen_vld <= 1'b0;
      end else if (req_valid && req_ack && req_op == 2'd1) begin
         seen_up  <= req_rdata[REG_W-1:TRIM_W];
         seen_vld <= 1'b1;
      end
   end

   // R1
   fields_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd2 && seen_vld) |-> (req_wdata[REG_W-1:TRIM_W] == seen_up));

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ack) |=> (req_valid && $stable(req_op) && $stable(req_wdata)));

   // R10
   req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);

   // R7
   abort_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cal_err) |-> (cal_trim == TRIM_W'(DEFAULT_TRIM)));

endmodule

bind trim_cal_ctrl trim_cal_chk #(
   .REG_W       (REG_W),
   .TRIM_W      (TRIM_W),
   .DEFAULT_TRIM(DEFAULT_TRIM)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .cal_err  (cal_err),
   .cal_trim (cal_trim),
   .req_valid(req_valid),
   .req_op   (req_op),
   .req_wdata(req_wdata),
   .req_ack  (req_ack),
   .req_rdata(req_rdata)
);

// File: tb/trim_cal_ctrl_bench.sv
module trim_cal_ctrl_bench;

   localparam int TIMEOUT = 300;
   localparam int SETTLE  = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, cal_err;
   logic [6:0]  cal_trim;
   logic        req_valid;
   logic [1:0]  req_op;
   logic [15:0] req_wdata;
   logic        req_ack = 1'b0;
   logic [15:0] req_rdata = '0;
   logic        data_in = 1'b0;

   trim_cal_ctrl #(
      .CLK_HZ     (125_000_000),
      .TARGET_NS  (800),
      .TIMEOUT_CYC(TIMEOUT),
      .SETTLE_CYC (SETTLE)
   ) u_trim_cal_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .done     (done),
      .cal_err  (cal_err),
      .cal_trim (cal_trim),
      .req_valid(req_valid),
      .req_op   (req_op),
      .req_wdata(req_wdata),
      .req_ack  (req_ack),
      .req_rdata(req_rdata),
      .data_in  (data_in)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // receiver model state
   localparam int MD_NORMAL = 0, MD_NOPULSE = 1, MD_STUCK = 2;
   int          mode = MD_NORMAL;
   int          offs = 200;
   bit          chatter = 1'b0;
   logic [15:0] dev_reg = '0;
   int          n_rd, n_wr, n_ex;
   int          exit_cyc, done_cyc, n_done;
   int          op_seq [0:31];
   logic [15:0] wr_log [0:15];
   int          n_ops;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (n_done == 0) done_cyc = cyc;
         n_done++;
      end
   end

   initial begin
      logic [1:0]  op;
      logic [15:0] wd;
      int          w;
      forever begin
         @(negedge clk);
         if (rst_n && req_valid) begin
            op = req_op;
            wd = req_wdata;
            data_in = 1'b0;
            repeat (2) @(negedge clk);
            if (n_ops < 32) op_seq[n_ops] = int'(op);
            n_ops++;
            if (op == 2'd2) begin
               dev_reg = wd;
               if (n_wr < 16) wr_log[n_wr] = wd;
               n_wr++;
            end
            if (op == 2'd1) begin
               req_rdata = dev_reg;
               n_rd++;
            end
            req_ack = 1'b1;
            @(negedge clk);
            req_ack = 1'b0;
            if (op == 2'd3) begin
               exit_cyc = cyc;
               n_ex++;
               if (chatter) begin
                  for (int i = 0; i < 20; i++) begin
                     @(negedge clk);
                     data_in = ~data_in;
                  end
                  data_in = 1'b0;
               end
            end
            if (op == 2'd1 && mode != MD_NOPULSE) begin
               repeat (3) @(negedge clk);
               data_in = 1'b1;
               if (mode == MD_NORMAL) begin
                  w = offs - int'(dev_reg[6:0]);
                  repeat (w) @(negedge clk);
                  data_in = 1'b0;
               end
            end
         end
      end
   end

   task automatic run_cal(input int md, input int off, input bit chat, input logic [15:0] init);
      mode = md; offs = off; chatter = chat; dev_reg = init;
      n_rd = 0; n_wr = 0; n_ex = 0; n_ops = 0; n_done = 0;
      exit_cyc = -1; done_cyc = -1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 20000 && n_done == 0; i++) @(negedge clk);
      if (n_done == 0) begin
         failures++;
         $display("FAIL R9 actual=no_done expected=done");
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic check_common(input string tag, input logic [15:0] init, input int wr_exp);
      // R2 ordering: read first, write/read alternate, last write then exit
      chk({tag, " R2 reads"}, n_rd, wr_exp);
      chk({tag, " R2 writes"}, n_wr, wr_exp);
      chk({tag, " R2 exits"}, n_ex, 1);
      chk({tag, " R2 first op"}, op_seq[0], 1);
      chk({tag, " R2 last op"}, op_seq[n_ops-1], 3);
      for (int i = 0; i < n_wr && i < 16; i++)
         chk({tag, " R1 upper fields"}, int'(wr_log[i][15:7]), int'(init[15:7]));
      // R9 done exactly SETTLE cycles after exit ack, single pulse
      chk({tag, " R9 settle cycles"}, done_cyc - exit_cyc, SETTLE);
      chk({tag, " R9 single done"}, n_done, 1);
      chk({tag, " R9 idle after"}, int'(busy), 0);
   endtask

   task automatic test_reset();
      chk("R10 busy", int'(busy), 0);
      chk("R10 done", int'(done), 0);
      chk("R10 req_valid", int'(req_valid), 0);
   endtask

   task automatic test_search_order();
      int exp_p [7] = '{64, 96, 112, 104, 100, 98, 99};
      run_cal(MD_NORMAL, 200, 1'b0, 16'hA5AC);
      check_common("A", 16'hA5AC, 8);
      for (int i = 0; i < 7; i++)
         chk("R3 R4 probe", int'(wr_log[i][6:0]), exp_p[i]);
      chk("R4 final trim", int'(wr_log[7][6:0]), 100);
      chk("R6 cal_trim", int'(cal_trim), 100);
      chk("R6 cal_err", int'(cal_err), 0);
   endtask

   task automatic test_best_not_last();
      run_cal(MD_NORMAL, 164, 1'b1, 16'h3AAC);
      check_common("B", 16'h3AAC, 8);
      chk("R3 first probe", int'(wr_log[0][6:0]), 64);
      chk("R5 last probe", int'(wr_log[6][6:0]), 63);
      chk("R5 final trim", int'(wr_log[7][6:0]), 64);
      chk("R6 cal_trim", int'(cal_trim), 64);
      chk("R6 cal_err", int'(cal_err), 0);
   endtask

   task automatic test_no_pulse();
      run_cal(MD_NOPULSE, 200, 1'b0, 16'h5F91);
      check_common("C", 16'h5F91, 1);
      chk("R7 cal_err", int'(cal_err), 1);
      chk("R7 default write", int'(wr_log[0][6:0]), 44);
      chk("R7 cal_trim", int'(cal_trim), 44);
   endtask

   task automatic test_stuck();
      run_cal(MD_STUCK, 200, 1'b0, 16'hC2AC);
      check_common("D", 16'hC2AC, 1);
      chk("R8 cal_err", int'(cal_err), 1);
      chk("R8 default write", int'(wr_log[0][6:0]), 44);
      chk("R8 cal_trim", int'(cal_trim), 44);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_search_order();
      test_best_not_last();
      test_no_pulse();
      test_stuck();
      test_search_order();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule